// File: doc/BRIEF.md
# Calendar Clock with Alarms

This block keeps wall-clock time (seconds, minutes, hours with an optional AM/PM flag) and a calendar (century, two-digit year, month, day of week, date), all held in BCD. A single-cycle pulse on `tick` advances it by one second. Generating that pulse from a crystal is not part of the block. It also raises periodic time and calendar event flags, and it raises an alarm when every enabled alarm field matches the clock. The flags feed one interrupt line through a mask.

Software reaches the block through a word-addressed register port with a write strobe and a combinational read path. To load new time or calendar values, software first sets the matching update request bit. This freezes that part of the counter and raises an acknowledge flag. Software then writes the new value and clears the request. Any out-of-range entry is rejected and reported through a validity register.

Register map (word address, fields):
- 0 control: [0] time update request, [1] calendar update request, [3:2] time event select, [5:4] calendar event select, [6] 12-hour mode.
- 1 time: [6:0] seconds, [14:8] minutes, [21:16] hours, [22] PM.
- 2 calendar: [5:0] date, [10:8] day of week, [15:11] month, [23:16] year, [29:24] century.
- 3 time alarm: the same layout as the time register, with enables at [7] seconds, [15] minutes and [23] hours.
- 4 calendar alarm: [5:0] date with enable [7], [12:8] month with enable [15].
- 5 status, read only: [0] acknowledge, [1] alarm, [2] second event, [3] time event, [4] calendar event.
- 6 status clear: write ones to clear flags.
- 7 mask: a write ORs ones into the mask; a read returns the mask.
- 8 mask disable: a write clears mask bits.
- 9 validity, read only: [0] time, [1] calendar, [2] time alarm, [3] calendar alarm. A 1 means the last write to that register was rejected.

Top module: `calclk`

## Requirements
- R1: After reset the clock reads 00:00:00 in 24-hour mode, and the calendar reads century 20, year 00, month 01, date 01, day of week 6. The control, status, mask and validity registers read 0, and `irq` is low.
- R2: In 24-hour mode each tick, when time is not frozen, adds one second in BCD. Seconds and minutes wrap 59 to 00 with a carry. Hours wrap 23 to 00, and that wrap advances the calendar by one day.
- R3: In 12-hour mode hours run 12, 01 ... 11. Going from 11:59:59 to 12:00:00 toggles PM (bit 22). Going from PM to AM advances the calendar by one day.
- R4: A day advance moves the day of week from 7 to 1, otherwise up by one. The date rolls to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months except February, and 28 for February, or 29 when the year's value is divisible by 4. Month 12 rolls to 01 and increments the year. Year 99 rolls to 00 and increments the century.
- R5: While the time (or calendar) update request is set, ticks do not change that part. Setting a request bit sets status bit 0 in the same write. Writes to the time or calendar register are ignored unless its request bit is set.
- R6: A write of an out-of-range or non-BCD value is rejected and sets its validity bit. A valid write stores the value and clears that bit. Hours must be 01 to 12 in 12-hour mode and 00 to 23 in 24-hour mode. Alarm months must be 01 to 12 and alarm dates 01 to 31.
- R7: The time event flag (status bit 3) is set on a counted tick according to the time event select: 0 on a new minute, 1 on a new hour, 2 on reaching midnight, 3 on reaching noon.
- R8: The calendar event flag (status bit 4) is set on a day advance according to the calendar event select: 0 when the new day of week is 1, 1 when the new date is 01, 2 when the new date is January 01. A select of 3 never sets it.
- R9: On a counted tick the alarm flag (status bit 1) is set when at least one alarm enable is set and every enabled field equals the clock after that tick. No enables means no alarm.
- R10: The second event flag (status bit 2) is set on every counted tick. Writing ones to the clear register clears only those status bits.
- R11: `irq` is high exactly when some status bit and its mask bit are both set. Mask bits are set by writes to address 7 and cleared by writes to address 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest cases to reach from the ports are the long-distance carries: a month end, a leap day, and the year and century rollover. Reaching them by counting would take months of ticks. The stimulus instead uses the update handshake to plant the calendar on the last day of each month of a leap and a non-leap year, with the clock at 23:59:59, and then gives a single tick. A second hard-to-reach case is a frozen calendar while time keeps counting. It is reached by holding only the calendar request across midnight. Long tick sweeps in both hour modes compare every second against an arithmetic seconds-of-day model.

// File: rtl/calclk_pkg.sv
// Shared types and BCD helpers for the calendar clock.
// Assumes all stored fields are packed BCD.
package calclk_pkg;

    typedef struct packed {
        logic       pm;
        logic [5:0] hr;
        logic [6:0] mn;
        logic [6:0] sc;
    } tod_t;

    typedef struct packed {
        logic [5:0] cent;
        logic [7:0] yr;
        logic [4:0] mon;
        logic [2:0] dow;
        logic [5:0] dt;
    } cal_t;

    // True when v is valid two-digit BCD and not above lim.
    function automatic logic bcd_le(input logic [7:0] v, input logic [7:0] lim);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= lim);
    endfunction

    // BCD increment of a valid value (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
    endfunction

    // Leap year test on a BCD year: 10 = 2 (mod 4).
    function automatic logic is_leap(input logic [7:0] y);
        logic [5:0] s;
        s = {1'b0, y[7:4], 1'b0} + {2'b0, y[3:0]};
        return s[1:0] == 2'b00;
    endfunction

    // Last date of a month, BCD.
    function automatic logic [5:0] month_end(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return is_leap(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic logic hour_ok(input logic [5:0] h, input logic m12);
        return m12 ? (bcd_le({2'b0, h}, 8'h12) && (h != 6'h00))
                   : bcd_le({2'b0, h}, 8'h23);
    endfunction

    function automatic logic tod_ok(input tod_t t, input logic m12);
        return bcd_le({1'b0, t.sc}, 8'h59) && bcd_le({1'b0, t.mn}, 8'h59) && hour_ok(t.hr, m12);
    endfunction

    function automatic logic cal_ok(input cal_t c);
        return bcd_le({2'b0, c.cent}, 8'h39) && bcd_le(c.yr, 8'h99)
            && bcd_le({3'b0, c.mon}, 8'h12) && (c.mon != 5'h00) && (c.dow != 3'd0)
            && (c.dt != 6'h00) && bcd_le({2'b0, c.dt}, {2'b0, month_end(c.mon, c.yr)});
    endfunction

endpackage

// File: rtl/calclk_tod.sv
// Time-of-day counter. Holds sec/min/hour/pm; steps one second on 'step',
// loads on 'load'. Exposes the value after one step and a day-wrap carry.
// Assumes the held value is valid for the current hour mode.
module calclk_tod
    import calclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic m12,
    input  logic load,
    input  tod_t load_val,
    output tod_t cur,
    output tod_t nxt,
    output logic day_wrap
);
    logic [7:0] sc_i, mn_i, hr_i;

    // Next-second value and day carry.
    always_comb begin
        sc_i     = bcd_inc({1'b0, cur.sc});
        mn_i     = bcd_inc({1'b0, cur.mn});
        hr_i     = bcd_inc({2'b0, cur.hr});
        nxt      = cur;
        day_wrap = 1'b0;
        if (cur.sc == 7'h59) begin
            nxt.sc = 7'h00;
            if (cur.mn == 7'h59) begin
                nxt.mn = 7'h00;
                if (m12) begin
                    if (cur.hr == 6'h11) begin
                        nxt.hr   = 6'h12;
                        nxt.pm   = ~cur.pm;
                        day_wrap = cur.pm;
                    end else if (cur.hr == 6'h12) begin
                        nxt.hr = 6'h01;
                    end else begin
                        nxt.hr = hr_i[5:0];
                    end
                end else if (cur.hr == 6'h23) begin
                    nxt.hr   = 6'h00;
                    day_wrap = 1'b1;
                end else begin
                    nxt.hr = hr_i[5:0];
                end
            end else begin
                nxt.mn = mn_i[6:0];
            end
        end else begin
            nxt.sc = sc_i[6:0];
        end
    end

    // Time register: load wins, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= '0;
        else if (load) cur <= load_val;
        else if (step) cur <= nxt;
    end

endmodule

// File: rtl/calclk_date.sv
// Calendar counter. Holds century/year/month/day-of-week/date; advances
// one day on 'step' with month-length and leap-year rollover.
// Assumes the held value is a valid calendar entry.
module calclk_date
    import calclk_pkg::*;
#(
    parameter cal_t RST_VAL = '{cent: 6'h20, yr: 8'h00, mon: 5'h01, dow: 3'd6, dt: 6'h01}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load,
    input  cal_t load_val,
    output cal_t cur,
    output cal_t nxt
);
    logic [7:0] dt_i, mon_i, yr_i, ce_i;

    // Next-day value.
    always_comb begin
        dt_i    = bcd_inc({2'b0, cur.dt});
        mon_i   = bcd_inc({3'b0, cur.mon});
        yr_i    = bcd_inc(cur.yr);
        ce_i    = bcd_inc({2'b0, cur.cent});
        nxt     = cur;
        nxt.dow = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
        if (cur.dt >= month_end(cur.mon, cur.yr)) begin
            nxt.dt = 6'h01;
            if (cur.mon >= 5'h12) begin
                nxt.mon = 5'h01;
                if (cur.yr == 8'h99) begin
                    nxt.yr   = 8'h00;
                    nxt.cent = ce_i[5:0];
                end else begin
                    nxt.yr = yr_i;
                end
            end else begin
                nxt.mon = mon_i[4:0];
            end
        end else begin
            nxt.dt = dt_i[5:0];
        end
    end

    // Calendar register: load wins, else step.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= RST_VAL;
        else if (load) cur <= load_val;
        else if (step) cur <= nxt;
    end

endmodule

// File: rtl/calclk_match.sv
// Field-masked alarm comparator. Purely combinational; assumes the
// alarm fields use the same BCD encoding as the counters.
module calclk_match
    import calclk_pkg::*;
(
    input  tod_t       now,
    input  cal_t       today,
    input  tod_t       alm,
    input  logic [2:0] t_en,    // [0] sec, [1] min, [2] hour+pm
    input  logic [4:0] alm_mon,
    input  logic [5:0] alm_dt,
    input  logic [1:0] c_en,    // [0] date, [1] month
    output logic       hit
);
    // All enabled fields equal, at least one enabled.
    always_comb begin
        hit = (|{t_en, c_en})
           && (!t_en[0] || (now.sc == alm.sc))
           && (!t_en[1] || (now.mn == alm.mn))
           && (!t_en[2] || ((now.hr == alm.hr) && (now.pm == alm.pm)))
           && (!c_en[0] || (today.dt == alm_dt))
           && (!c_en[1] || (today.mon == alm_mon));
    end
endmodule

// File: rtl/calclk.sv
// Calendar clock top: register port, update handshake, validity checks,
// event and alarm flags, masked interrupt. Assumes 'tick' is one cycle
// wide and at most one per second; reads are combinational.
module calclk
    import calclk_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int FLAG_W = 5,
    parameter int BAD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = 0, A_TIME = 1, A_CAL = 2, A_TALM = 3, A_CALM = 4,
                                  A_STAT = 5, A_CLR = 6, A_MSET = 7, A_MCLR = 8, A_BAD = 9;

    logic              treq, creq, m12;
    logic [1:0]        tsel, csel;
    tod_t              alm_t;
    logic [2:0]        t_en;
    logic [4:0]        a_mon;
    logic [5:0]        a_dt;
    logic [1:0]        c_en;
    logic [FLAG_W-1:0] stat, mask, flag_set, flag_clr;
    logic [BAD_W-1:0]  bad;

    tod_t tod_cur, tod_nxt, w_tod, w_talm;
    cal_t cal_cur, cal_nxt, w_cal, today;
    logic day_wrap, t_step, c_step, t_load, c_load, alm_hit;
    logic wr_ctrl, wr_time, wr_cal, wr_talm, wr_calm;
    logic mid, noon, min_ch, hr_ch, t_ev, c_ev, calm_ok;

    // Write decode and field extraction.
    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_time = wr_en && (addr == A_TIME);
        wr_cal  = wr_en && (addr == A_CAL);
        wr_talm = wr_en && (addr == A_TALM);
        wr_calm = wr_en && (addr == A_CALM);
        w_tod   = '{pm: wdata[22] & m12, hr: wdata[21:16], mn: wdata[14:8], sc: wdata[6:0]};
        w_talm  = w_tod;
        w_cal   = '{cent: wdata[29:24], yr: wdata[23:16], mon: wdata[15:11],
                    dow: wdata[10:8], dt: wdata[5:0]};
        calm_ok = bcd_le({3'b0, wdata[12:8]}, 8'h12) && (wdata[12:8] != 5'h00)
               && bcd_le({2'b0, wdata[5:0]}, 8'h31) && (wdata[5:0] != 6'h00);
        t_load  = wr_time && treq && tod_ok(w_tod, m12);
        c_load  = wr_cal && creq && cal_ok(w_cal);
        t_step  = tick && !treq;
        c_step  = t_step && day_wrap && !creq;
    end

    calclk_tod i_tod (
        .clk(clk), .rst_n(rst_n), .step(t_step), .m12(m12), .load(t_load),
        .load_val(w_tod), .cur(tod_cur), .nxt(tod_nxt), .day_wrap(day_wrap)
    );

    calclk_date i_date (
        .clk(clk), .rst_n(rst_n), .step(c_step), .load(c_load),
        .load_val(w_cal), .cur(cal_cur), .nxt(cal_nxt)
    );

    calclk_match i_match (
        .now(tod_nxt), .today(today), .alm(alm_t), .t_en(t_en),
        .alm_mon(a_mon), .alm_dt(a_dt), .c_en(c_en), .hit(alm_hit)
    );

    // Event selection on the post-tick values.
    always_comb begin
        today  = c_step ? cal_nxt : cal_cur;
        min_ch = (tod_nxt.sc == 7'h00);
        hr_ch  = min_ch && (tod_nxt.mn == 7'h00);
        mid    = m12 ? ((tod_nxt.hr == 6'h12) && !tod_nxt.pm) : (tod_nxt.hr == 6'h00);
        noon   = m12 ? ((tod_nxt.hr == 6'h12) && tod_nxt.pm) : (tod_nxt.hr == 6'h12);
        case (tsel)
            2'd0:    t_ev = min_ch;
            2'd1:    t_ev = hr_ch;
            2'd2:    t_ev = hr_ch && mid;
            default: t_ev = hr_ch && noon;
        endcase
        case (csel)
            2'd0:    c_ev = (cal_nxt.dow == 3'd1);
            2'd1:    c_ev = (cal_nxt.dt == 6'h01);
            2'd2:    c_ev = (cal_nxt.dt == 6'h01) && (cal_nxt.mon == 5'h01);
            default: c_ev = 1'b0;
        endcase
        flag_set = {c_step && c_ev, t_step && t_ev, t_step, t_step && alm_hit,
                    wr_ctrl && ((wdata[1:0] & ~{creq, treq}) != 2'b00)};
        flag_clr = (wr_en && (addr == A_CLR)) ? wdata[FLAG_W-1:0] : '0;
    end

    // Control, alarm, mask, status and validity registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {treq, creq, m12, tsel, csel} <= '0;
            alm_t <= '0; t_en <= '0; a_mon <= 5'h01; a_dt <= 6'h01; c_en <= '0;
            stat  <= '0; mask <= '0; bad <= '0;
        end else begin
            if (wr_ctrl) {m12, csel, tsel, creq, treq} <= wdata[6:0];
            if (wr_time && treq) bad[0] <= !t_load;
            if (wr_cal && creq)  bad[1] <= !c_load;
            if (wr_talm) begin
                bad[2] <= !tod_ok(w_talm, m12);
                if (tod_ok(w_talm, m12)) begin
                    alm_t <= w_talm;
                    t_en  <= {wdata[23], wdata[15], wdata[7]};
                end
            end
            if (wr_calm) begin
                bad[3] <= !calm_ok;
                if (calm_ok) begin
                    a_mon <= wdata[12:8];
                    a_dt  <= wdata[5:0];
                    c_en  <= {wdata[15], wdata[7]};
                end
            end
            if (wr_en && (addr == A_MSET)) mask <= mask | wdata[FLAG_W-1:0];
            if (wr_en && (addr == A_MCLR)) mask <= mask & ~wdata[FLAG_W-1:0];
            stat <= (stat & ~flag_clr) | flag_set;
        end
    end

    // Read mux and interrupt.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {25'b0, m12, csel, tsel, creq, treq};
            A_TIME:  rdata = {9'b0, tod_cur.pm, tod_cur.hr, 1'b0, tod_cur.mn, 1'b0, tod_cur.sc};
            A_CAL:   rdata = {2'b0, cal_cur.cent, cal_cur.yr, cal_cur.mon, cal_cur.dow, 2'b0, cal_cur.dt};
            A_TALM:  rdata = {8'b0, t_en[2], alm_t.pm, alm_t.hr, t_en[1], alm_t.mn, t_en[0], alm_t.sc};
            A_CALM:  rdata = {16'b0, c_en[1], 2'b0, a_mon, c_en[0], 1'b0, a_dt};
            A_STAT:  rdata = {{(32-FLAG_W){1'b0}}, stat};
            A_MSET:  rdata = {{(32-FLAG_W){1'b0}}, mask};
            A_BAD:   rdata = {{(32-BAD_W){1'b0}}, bad};
            default: rdata = '0;
        endcase
        irq = |(stat & mask);
    end

endmodule

// File: rtl/calclk_chk.sv
// Assertion checker bound into calclk. Observes ports and the held
// time/calendar state; drives nothing.
module calclk_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              treq,
    input logic [4:0]        stat_q,
    input logic [20:0]       tod_q,
    input logic [27:0]       cal_q
);
    // R2: seconds always a valid BCD value 00..59
    a_r2_sec_bcd: assert property (@(posedge clk) disable iff (!rst_n)
        (tod_q[3:0] <= 4'd9) && (tod_q[6:0] <= 7'h59));

    // R4: date stays within 01..31
    a_r4_date_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_q[5:0] != 6'h00) && (cal_q[5:0] <= 6'h31));

    // R5: pending time request freezes the time unless it is being written
    a_r5_frozen_time: assert property (@(posedge clk) disable iff (!rst_n)
        (treq && !(wr_en && (addr == ADDR_W'(1)))) |=> $stable(tod_q));

    // R5: time write without request has no effect when no tick arrives
    a_r5_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!treq && !tick && wr_en && (addr == ADDR_W'(1))) |=> $stable(tod_q));

    // R5: acknowledge only rises after a control write
    a_r5_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[0]) |-> $past(wr_en && (addr == ADDR_W'(0))));

    // R10: clearing the second event without a tick leaves it clear
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(6)) && wdata[2] && !tick) |=> !stat_q[2]);
endmodule

bind calclk calclk_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .treq(treq), .stat_q(stat), .tod_q(tod_cur), .cal_q(cal_cur)
);

// File: tb/test_calclk.sv
module test_calclk;
    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          total = 0, bad = 0;
    logic [31:0] ctrl_sh = '0;

    calclk i_calclk (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                     .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [31:0] b2(input int v);
        return 32'(((v / 10) << 4) | (v % 10));
    endfunction
    function automatic logic [31:0] tv(input int h, input int m, input int s, input int pm);
        return (32'(pm) << 22) | (b2(h) << 16) | (b2(m) << 8) | b2(s);
    endfunction
    function automatic logic [31:0] cv(input int ce, input int y, input int mo, input int dw, input int d);
        return (b2(ce) << 24) | (b2(y) << 16) | (b2(mo) << 11) | (32'(dw) << 8) | b2(d);
    endfunction
    function automatic logic [31:0] tod_of(input int s, input bit m12);
        int h;
        h = s / 3600;
        if (m12) return tv((h % 12 == 0) ? 12 : h % 12, (s / 60) % 60, s % 60, (h >= 12) ? 1 : 0);
        return tv(h, (s / 60) % 60, s % 60, 0);
    endfunction
    function automatic int last_day(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask
    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a; #1; v = rdata;
    endtask
    task automatic tk();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask
    task automatic set_ctrl(input logic [31:0] v);
        ctrl_sh = v; wr(4'd0, v);
    endtask
    task automatic set_time(input logic [31:0] v);
        wr(4'd0, ctrl_sh | 32'h1); wr(4'd1, v); wr(4'd0, ctrl_sh);
    endtask
    task automatic set_cal(input logic [31:0] v);
        wr(4'd0, ctrl_sh | 32'h2); wr(4'd2, v); wr(4'd0, ctrl_sh);
    endtask
    // Tick sweep against a seconds-of-day model (hour events selected).
    task automatic sweep(input string tag, input int s0, input int n, input bit m12);
        logic [31:0] v;
        int s;
        s = s0;
        set_time(tod_of(s0, m12));
        wr(4'd6, 32'h1F);
        for (int i = 0; i < n; i++) begin
            tk();
            s = (s + 1) % 86400;
            rd(4'd1, v); chk(tag, v, tod_of(s, m12));
            rd(4'd5, v);
            chk("R7 hour event", {31'b0, v[3]}, {31'b0, (s % 3600) == 0});
            chk("R10 second event", {31'b0, v[2]}, 32'd1);
            wr(4'd6, 32'h1F);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4'd1, v); chk("R1 time", v, 32'h0);
        rd(4'd2, v); chk("R1 calendar", v, cv(20, 0, 1, 6, 1));
        rd(4'd0, v); chk("R1 control", v, 32'h0);
        rd(4'd5, v); chk("R1 status", v, 32'h0);
        rd(4'd9, v); chk("R1 validity", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'd0);

        // R2 24-hour sweep across midnight, hour events (select 1)
        set_ctrl(32'h04);
        sweep("R2 time 24h", 81000, 7200, 1'b0);
        rd(4'd2, v); chk("R4 day advance from midnight", v, cv(20, 0, 1, 7, 2));

        // R3 12-hour sweeps across noon and midnight
        set_ctrl(32'h44);
        sweep("R3 time 12h noon", 42600, 1500, 1'b0 | 1'b1);
        sweep("R3 time 12h midnight", 85800, 1500, 1'b1);
        rd(4'd2, v); chk("R3 PM to AM advances date", v, cv(20, 0, 1, 1, 3));

        // R7 midnight / noon / minute selects
        set_ctrl(32'h08);
        set_time(tv(23, 59, 59, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R7 midnight select", {31'b0, v[3]}, 32'd1);
        set_time(tv(22, 59, 59, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R7 midnight select other hour", {31'b0, v[3]}, 32'd0);
        set_ctrl(32'h0C);
        set_time(tv(11, 59, 59, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R7 noon select", {31'b0, v[3]}, 32'd1);
        set_time(tv(12, 59, 59, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R7 noon select other hour", {31'b0, v[3]}, 32'd0);
        set_ctrl(32'h00);
        set_time(tv(10, 20, 59, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R7 minute select", {31'b0, v[3]}, 32'd1);
        set_time(tv(10, 20, 30, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R7 minute select mid-minute", {31'b0, v[3]}, 32'd0);

        // R4 and R8: every month end of a leap and non-leap year, month select
        set_ctrl(32'h10);
        foreach (v0[i]) if (i < 3) begin
            int y;
            y = (i == 0) ? 0 : ((i == 1) ? 23 : 24);
            for (int m = 1; m <= 12; m++) begin
                set_cal(cv(20, y, m, 3, last_day(m, y)));
                set_time(tv(23, 59, 59, 0)); wr(4'd6, 32'h1F); tk();
                rd(4'd2, v);
                chk("R4 month end", v, cv(20, (m == 12) ? y + 1 : y, (m == 12) ? 1 : m + 1, 4, 1));
                rd(4'd5, v); chk("R8 month select", {31'b0, v[4]}, 32'd1);
            end
        end
        // R4 day before month end does not roll the month
        set_cal(cv(20, 23, 2, 2, 27));
        set_time(tv(23, 59, 59, 0)); tk();
        rd(4'd2, v); chk("R4 Feb 28 in non-leap year", v, cv(20, 23, 2, 3, 28));

        // R8 year select and century rollover
        set_ctrl(32'h20);
        set_cal(cv(20, 99, 12, 5, 31));
        set_time(tv(23, 59, 59, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd2, v); chk("R4 century rollover", v, cv(21, 0, 1, 6, 1));
        rd(4'd5, v); chk("R8 year select", {31'b0, v[4]}, 32'd1);
        set_cal(cv(20, 24, 4, 2, 30));
        set_time(tv(23, 59, 59, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R8 year select not January", {31'b0, v[4]}, 32'd0);
        // R8 week select and select 3
        set_ctrl(32'h00);
        set_cal(cv(20, 24, 3, 7, 10));
        set_time(tv(23, 59, 59, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd2, v); chk("R4 weekday wrap", v, cv(20, 24, 3, 1, 11));
        rd(4'd5, v); chk("R8 week select", {31'b0, v[4]}, 32'd1);
        set_ctrl(32'h30);
        set_cal(cv(20, 24, 3, 7, 10));
        set_time(tv(23, 59, 59, 0)); wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R8 select 3 never", {31'b0, v[4]}, 32'd0);

        // R5 freeze, acknowledge, ignored write
        set_ctrl(32'h00);
        set_time(tv(7, 0, 0, 0));
        wr(4'd6, 32'h1F);
        wr(4'd0, 32'h1);
        rd(4'd5, v); chk("R5 acknowledge", {31'b0, v[0]}, 32'd1);
        rd(4'd1, v0);
        repeat (3) tk();
        rd(4'd1, v); chk("R5 frozen time", v, v0);
        wr(4'd1, tv(8, 0, 0, 0)); wr(4'd0, 32'h0); tk();
        rd(4'd1, v); chk("R5 resume after release", v, tv(8, 0, 1, 0));
        wr(4'd1, tv(9, 9, 9, 0));
        rd(4'd1, v); chk("R5 write without request ignored", v, tv(8, 0, 1, 0));
        set_cal(cv(20, 24, 6, 1, 5));
        wr(4'd0, 32'h3); wr(4'd1, tv(23, 59, 59, 0)); wr(4'd0, 32'h2); tk();
        rd(4'd1, v); chk("R5 time runs with calendar frozen", v, tv(0, 0, 0, 0));
        rd(4'd2, v); chk("R5 calendar frozen", v, cv(20, 24, 6, 1, 5));
        wr(4'd0, 32'h0);

        // R6 validity
        wr(4'd0, 32'h1);
        wr(4'd1, tv(12, 0, 0, 0));
        wr(4'd1, 32'h0024_0000);
        rd(4'd9, v); chk("R6 hour 24 rejected", {31'b0, v[0]}, 32'd1);
        rd(4'd1, v); chk("R6 rejected time not stored", v, tv(12, 0, 0, 0));
        wr(4'd1, 32'h0000_001A);
        rd(4'd9, v); chk("R6 non-BCD second rejected", {31'b0, v[0]}, 32'd1);
        wr(4'd1, tv(1, 2, 3, 0));
        rd(4'd9, v); chk("R6 valid write clears flag", {31'b0, v[0]}, 32'd0);
        wr(4'd0, 32'h41);
        wr(4'd1, tv(0, 10, 0, 0));
        rd(4'd9, v); chk("R6 hour 00 rejected in 12h", {31'b0, v[0]}, 32'd1);
        wr(4'd0, 32'h2);
        wr(4'd2, cv(20, 23, 2, 1, 29));
        rd(4'd9, v); chk("R6 Feb 29 non-leap rejected", {31'b0, v[1]}, 32'd1);
        wr(4'd2, cv(20, 24, 2, 4, 29));
        rd(4'd9, v); chk("R6 Feb 29 leap accepted", {31'b0, v[1]}, 32'd0);
        rd(4'd2, v); chk("R6 leap date stored", v, cv(20, 24, 2, 4, 29));
        wr(4'd0, 32'h0); ctrl_sh = 32'h0;
        wr(4'd3, 32'h0000_6000);
        rd(4'd9, v); chk("R6 alarm minute 60 rejected", {31'b0, v[2]}, 32'd1);
        wr(4'd4, 32'h0000_1301);
        rd(4'd9, v); chk("R6 alarm month 13 rejected", {31'b0, v[3]}, 32'd1);

        // R9 alarm on minute and second, R11 mask
        wr(4'd3, 32'h0000_8085);
        wr(4'd4, 32'h0000_0101);
        set_time(tv(10, 59, 58, 0)); wr(4'd6, 32'h1F);
        repeat (6) tk();
        rd(4'd5, v); chk("R9 no alarm before match", {31'b0, v[1]}, 32'd0);
        tk();
        rd(4'd5, v); chk("R9 alarm on match", {31'b0, v[1]}, 32'd1);
        chk("R11 irq masked", {31'b0, irq}, 32'd0);
        wr(4'd7, 32'h2);
        chk("R11 irq enabled", {31'b0, irq}, 32'd1);
        wr(4'd8, 32'h2);
        chk("R11 irq disabled", {31'b0, irq}, 32'd0);
        wr(4'd6, 32'h2);
        rd(4'd5, v); chk("R10 clear only written bits", v & 32'h6, 32'h4);
        // R9 date-only alarm
        set_cal(cv(20, 24, 5, 3, 15));
        wr(4'd3, 32'h0);
        wr(4'd4, 32'h0000_0195);
        wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R9 date alarm", {31'b0, v[1]}, 32'd1);
        wr(4'd4, 32'h0000_0196);
        wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R9 date mismatch", {31'b0, v[1]}, 32'd0);
        wr(4'd4, 32'h0000_0115);
        wr(4'd6, 32'h1F); tk();
        rd(4'd5, v); chk("R9 no enables no alarm", {31'b0, v[1]}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule